// File: doc/BRIEF.md
# Byte Stack Sequencer

This block owns the 8-bit stack pointer of a small processor core and turns single stack commands into sequences of one-byte accesses to a 128-byte internal register file. A command is accepted only while the unit is idle. It then runs one register-file access per clock cycle until the whole frame is done, and signals the end with a one-cycle done strobe. The frames are: a data byte push or pop, a status byte push or pop, a subroutine call or software trap (return address pushed, high byte first), a subroutine return (low byte popped first, then high), and an interrupt return (low byte, high byte, then status). The stack pointer can be loaded from an outside value and is always visible on an output.

A push increments the pointer first and writes at the new address. A pop reads at the current address first and then decrements. A pop at address 0x00 leaves the pointer at 0x00. The register file is read combinationally, so each popped byte is captured at the edge that ends its access cycle. Decoding instructions and choosing the new program counter after a call or trap are the caller's job. The caller does this after the done strobe.

Controller states: `S_IDLE` (waits for a command), `S_PUSH_HI` (writes the program counter high byte), `S_PUSH_LAST` (writes the held byte: data, status or program counter low byte), `S_POP_BYTE` (pops a data byte), `S_POP_LO` / `S_POP_HI` (pop the return address), `S_POP_STAT` (pops a status byte), `S_FINISH` (done strobe). Transitions: from `S_IDLE`, push and status push go to `S_PUSH_LAST`, call and trap go to `S_PUSH_HI`, pop goes to `S_POP_BYTE`, status pop goes to `S_POP_STAT`, subroutine return and interrupt return go to `S_POP_LO`, and load goes to `S_FINISH`. An unknown code stays in `S_IDLE`. `S_PUSH_HI` leads to `S_PUSH_LAST`, and `S_POP_LO` leads to `S_POP_HI`. From `S_POP_HI` an interrupt return goes to `S_POP_STAT` and every other frame goes to `S_FINISH`. The remaining access states lead to `S_FINISH`, and `S_FINISH` returns to `S_IDLE`.

Top module: `byte_stack_unit`

## Requirements
- R1: After reset the stack pointer is 0x01, and busy, done, write enable and read enable are all 0.
- R2: Push (code 1) writes the data byte at address sp+1, leaves the pointer at sp+1, and raises done 1 cycle after the acceptance cycle.
- R3: Pop (code 2) reads the byte at address sp into the popped-byte output, then decrements the pointer. Done comes 1 cycle after acceptance.
- R4: A pop with the pointer at 0x00 leaves it at 0x00. A push that follows writes address 0x01 and leaves the pointer at 0x01.
- R5: Call (code 5) and trap (code 6) write the program counter high byte at sp+1 and the low byte at sp+2, leave the pointer at sp+2, and raise done 2 cycles after acceptance.
- R6: Subroutine return (code 7) pops the low byte from sp and the high byte from sp-1 into the returned-PC output, leaves the pointer at sp-2, and raises done 2 cycles after acceptance.
- R7: Interrupt return (code 8) pops low byte, high byte and then status into the returned-PC and returned-status outputs, leaves the pointer at sp-3, and raises done 3 cycles after acceptance.
- R8: Status push (code 3) stores the status input as a pushed byte. Status pop (code 4) loads the returned-status output. Both raise done 1 cycle after acceptance.
- R9: Load (code 9) sets the pointer to the load value with done in the cycle right after acceptance. The pointer is always visible on its output.
- R10: While busy is high, new commands are ignored, and the pointer and the register file are touched only by the running frame.
- R11: The register-file address is the low 7 bits of the pointer (sp+1 for pushes), so pointer 0x85 pops address 0x05.
- R12: Done is a single-cycle pulse, after which busy is low. Write and read enables are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_code | input | 4 | Command code (see requirements) |
| pc_in | input | 16 | Program counter to push on call or trap |
| status_in | input | 8 | Status byte to push |
| data_in | input | 8 | Data byte to push |
| sp_load | input | 8 | Value for the load command |
| rf_rdata | input | 8 | Register-file read data, combinational to rf_addr |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Frame complete strobe |
| rf_addr | output | 7 | Register-file address |
| rf_wdata | output | 8 | Register-file write data |
| rf_we | output | 1 | Register-file write enable |
| rf_re | output | 1 | Register-file read access |
| sp_value | output | 8 | Current stack pointer |
| pop_byte | output | 8 | Last popped data byte |
| ret_pc | output | 16 | Popped return address |
| ret_status | output | 8 | Popped status byte |

## Verification
A command is accepted at the clock edge where it is presented to an idle unit. Done then rises as many cycles later as the frame has register-file accesses. Load takes no access, so its done comes in the cycle right after acceptance. The bench drives on falling edges and counts falling edges from the end of the command cycle until done, comparing that count with the expected number of accesses. Pointer, register-file contents and popped outputs are all final by the done cycle and are sampled there. A further falling edge is used to confirm that the done pulse has ended.

// File: rtl/bstk_pkg.sv
package bstk_pkg;
    typedef enum logic [3:0] {
        CMD_NONE    = 4'd0,
        CMD_PUSH    = 4'd1,
        CMD_POP     = 4'd2,
        CMD_PUSH_ST = 4'd3,
        CMD_POP_ST  = 4'd4,
        CMD_CALL    = 4'd5,
        CMD_TRAP    = 4'd6,
        CMD_RETS    = 4'd7,
        CMD_RETI    = 4'd8,
        CMD_LDSP    = 4'd9
    } bstk_cmd_e;

    typedef enum logic [2:0] {
        S_IDLE, S_PUSH_HI, S_PUSH_LAST, S_POP_BYTE,
        S_POP_LO, S_POP_HI, S_POP_STAT, S_FINISH
    } bstk_state_e;

    typedef enum logic [1:0] {
        RD_BYTE, RD_PCLO, RD_PCHI, RD_STAT
    } bstk_rdst_e;
endpackage

// File: rtl/bstk_ptr.sv
module bstk_ptr #(
    parameter int SP_W     = 8,
    parameter int RESET_SP = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inc,
    input  logic            dec,
    input  logic            ld,
    input  logic [SP_W-1:0] ld_val,
    output logic [SP_W-1:0] sp,
    output logic [SP_W-1:0] sp_up
);
    localparam logic [SP_W-1:0] ONE = SP_W'(1);

    assign sp_up = sp + ONE;

    always_ff @(posedge clk) begin
        if (!rst_n)
            sp <= SP_W'(RESET_SP);
        else if (ld)
            sp <= ld_val;
        else if (inc)
            sp <= sp_up;
        else if (dec && (sp != '0))
            sp <= sp - ONE;
    end
endmodule

// File: rtl/bstk_ctrl.sv
module bstk_ctrl
    import bstk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [3:0] cmd_code,
    output logic       accept,
    output logic       busy,
    output logic       done,
    output logic       sp_inc,
    output logic       sp_dec,
    output logic       sp_ld,
    output logic       rf_we,
    output logic       rf_re,
    output logic       wr_hi,
    output bstk_rdst_e rd_dst
);
    bstk_state_e state, state_nx;
    bstk_cmd_e   cmd;
    logic        chain_stat;

    assign cmd = bstk_cmd_e'(cmd_code);

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (cmd_valid) begin
                    case (cmd)
                        CMD_PUSH, CMD_PUSH_ST: state_nx = S_PUSH_LAST;
                        CMD_CALL, CMD_TRAP:    state_nx = S_PUSH_HI;
                        CMD_POP:               state_nx = S_POP_BYTE;
                        CMD_POP_ST:            state_nx = S_POP_STAT;
                        CMD_RETS, CMD_RETI:    state_nx = S_POP_LO;
                        CMD_LDSP:              state_nx = S_FINISH;
                        default:               state_nx = S_IDLE;
                    endcase
                end
            end
            S_PUSH_HI:   state_nx = S_PUSH_LAST;
            S_PUSH_LAST: state_nx = S_FINISH;
            S_POP_BYTE:  state_nx = S_FINISH;
            S_POP_LO:    state_nx = S_POP_HI;
            S_POP_HI:    state_nx = chain_stat ? S_POP_STAT : S_FINISH;
            S_POP_STAT:  state_nx = S_FINISH;
            S_FINISH:    state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            chain_stat <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept)
                chain_stat <= (cmd == CMD_RETI);
        end
    end

    // outputs
    always_comb begin
        accept = 1'b0;
        sp_inc = 1'b0;
        sp_dec = 1'b0;
        sp_ld  = 1'b0;
        rf_we  = 1'b0;
        rf_re  = 1'b0;
        wr_hi  = 1'b0;
        done   = 1'b0;
        rd_dst = RD_BYTE;
        busy   = (state != S_IDLE);
        unique case (state)
            S_IDLE: begin
                accept = (state_nx != S_IDLE);
                sp_ld  = cmd_valid && (cmd == CMD_LDSP);
            end
            S_PUSH_HI: begin
                rf_we  = 1'b1;
                sp_inc = 1'b1;
                wr_hi  = 1'b1;
            end
            S_PUSH_LAST: begin
                rf_we  = 1'b1;
                sp_inc = 1'b1;
            end
            S_POP_BYTE: begin
                rf_re  = 1'b1;
                sp_dec = 1'b1;
            end
            S_POP_LO: begin
                rf_re  = 1'b1;
                sp_dec = 1'b1;
                rd_dst = RD_PCLO;
            end
            S_POP_HI: begin
                rf_re  = 1'b1;
                sp_dec = 1'b1;
                rd_dst = RD_PCHI;
            end
            S_POP_STAT: begin
                rf_re  = 1'b1;
                sp_dec = 1'b1;
                rd_dst = RD_STAT;
            end
            S_FINISH: done = 1'b1;
        endcase
    end
endmodule

// File: rtl/byte_stack_unit.sv
module byte_stack_unit
    import bstk_pkg::*;
#(
    parameter int SP_W     = 8,
    parameter int ADDR_W   = 7,
    parameter int DATA_W   = 8,
    parameter int RESET_SP = 1,
    localparam int PC_W    = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_code,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [DATA_W-1:0] status_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic [SP_W-1:0]   sp_load,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              rf_we,
    output logic              rf_re,
    output logic [SP_W-1:0]   sp_value,
    output logic [DATA_W-1:0] pop_byte,
    output logic [PC_W-1:0]   ret_pc,
    output logic [DATA_W-1:0] ret_status
);
    logic              accept, sp_inc, sp_dec, sp_ld, wr_hi;
    bstk_rdst_e        rd_dst;
    logic [SP_W-1:0]   sp_up;
    logic [DATA_W-1:0] hold_byte, pc_hi_q;
    bstk_cmd_e         cmd;

    assign cmd = bstk_cmd_e'(cmd_code);

    bstk_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .accept    (accept),
        .busy      (busy),
        .done      (done),
        .sp_inc    (sp_inc),
        .sp_dec    (sp_dec),
        .sp_ld     (sp_ld),
        .rf_we     (rf_we),
        .rf_re     (rf_re),
        .wr_hi     (wr_hi),
        .rd_dst    (rd_dst)
    );

    bstk_ptr #(.SP_W(SP_W), .RESET_SP(RESET_SP)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (sp_inc),
        .dec    (sp_dec),
        .ld     (sp_ld),
        .ld_val (sp_load),
        .sp     (sp_value),
        .sp_up  (sp_up)
    );

    // capture of frame operands at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_byte <= '0;
            pc_hi_q   <= '0;
        end else if (accept) begin
            pc_hi_q <= pc_in[PC_W-1 -: DATA_W];
            case (cmd)
                CMD_PUSH_ST:        hold_byte <= status_in;
                CMD_CALL, CMD_TRAP: hold_byte <= pc_in[DATA_W-1:0];
                default:            hold_byte <= data_in;
            endcase
        end
    end

    assign rf_wdata = wr_hi ? pc_hi_q : hold_byte;
    assign rf_addr  = rf_we ? sp_up[ADDR_W-1:0] : sp_value[ADDR_W-1:0];

    // popped byte capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_byte   <= '0;
            ret_pc     <= '0;
            ret_status <= '0;
        end else if (rf_re) begin
            unique case (rd_dst)
                RD_BYTE: pop_byte                   <= rf_rdata;
                RD_PCLO: ret_pc[DATA_W-1:0]         <= rf_rdata;
                RD_PCHI: ret_pc[PC_W-1 -: DATA_W]   <= rf_rdata;
                RD_STAT: ret_status                 <= rf_rdata;
            endcase
        end
    end
endmodule

// File: rtl/bstk_chk.sv
module bstk_chk #(
    parameter int SP_W   = 8,
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              rf_we,
    input logic              rf_re,
    input logic [ADDR_W-1:0] rf_addr,
    input logic [SP_W-1:0]   sp_value
);
    localparam logic [SP_W-1:0] ONE = SP_W'(1);

    assert_push_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> rf_addr == ADDR_W'(sp_value + ONE));
    assert_push_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> sp_value == $past(sp_value) + ONE);
    assert_pop_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rf_re |-> rf_addr == sp_value[ADDR_W-1:0]);
    assert_pop_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_re && sp_value != '0) |=> sp_value == $past(sp_value) - ONE);
    assert_pop_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_re && sp_value == '0) |=> sp_value == '0);
    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rf_we && !rf_re) |=> $stable(sp_value));
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    assert_we_re_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_we && rf_re));
endmodule

bind byte_stack_unit bstk_chk #(.SP_W(SP_W), .ADDR_W(ADDR_W)) i_bstk_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .rf_we    (rf_we),
    .rf_re    (rf_re),
    .rf_addr  (rf_addr),
    .sp_value (sp_value)
);

// File: tb/test_byte_stack_unit.sv
`timescale 1ns/1ps
module test_byte_stack_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_code = 4'd0;
    logic [15:0] pc_in = 16'd0;
    logic [7:0]  status_in = 8'd0;
    logic [7:0]  data_in = 8'd0;
    logic [7:0]  sp_load = 8'd0;
    logic [7:0]  rf_rdata;
    logic        busy, done, rf_we, rf_re;
    logic [6:0]  rf_addr;
    logic [7:0]  rf_wdata, sp_value, pop_byte, ret_status;
    logic [15:0] ret_pc;

    logic        poke_en = 1'b0;
    logic [6:0]  poke_addr = 7'd0;
    logic [7:0]  poke_data = 8'd0;
    logic [7:0]  mem [0:127];

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    byte_stack_unit i_byte_stack_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .pc_in(pc_in), .status_in(status_in), .data_in(data_in), .sp_load(sp_load),
        .rf_rdata(rf_rdata), .busy(busy), .done(done), .rf_addr(rf_addr),
        .rf_wdata(rf_wdata), .rf_we(rf_we), .rf_re(rf_re), .sp_value(sp_value),
        .pop_byte(pop_byte), .ret_pc(ret_pc), .ret_status(ret_status)
    );

    always @(posedge clk) begin
        if (rf_we) mem[rf_addr] <= rf_wdata;
        if (poke_en) mem[poke_addr] <= poke_data;
    end
    assign rf_rdata = mem[rf_addr];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        poke_en = 1'b1; poke_addr = a; poke_data = d;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic run_cmd(input logic [3:0] c, input int lat, input string tag);
        int got;
        got = -1;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = c;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_code = 4'd0;
        for (int k = 0; k <= lat + 2; k++) begin
            if (done) begin
                got = k;
                break;
            end
            @(negedge clk);
        end
        check(got == lat, {tag, " done latency"}, got, lat);
    endtask

    task automatic after_done();
        @(negedge clk);
        check(!done && !busy, "R12 done single pulse", {done, busy}, 0);
    endtask

    task automatic load_sp(input logic [7:0] v);
        sp_load = v;
        run_cmd(4'd9, 0, "R9");
        check(sp_value == v, "R9 load value", sp_value, v);
    endtask

    initial begin
        logic [7:0] base;
        logic [7:0] sp_exp;
        logic [15:0] pcv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(sp_value == 8'h01, "R1 sp reset", sp_value, 1);
        check(!busy && !done && !rf_we && !rf_re, "R1 controls idle",
              {busy, done, rf_we, rf_re}, 0);

        // R9 / R11 / R3 / R4: load every value, then pop once
        for (int v = 0; v < 256; v++) begin
            load_sp(8'(v));
            poke(7'(v), 8'(v) ^ 8'h5A);
            run_cmd(4'd2, 1, "R3");
            check(pop_byte == (8'(v) ^ 8'h5A), "R11 pop address low bits",
                  pop_byte, 8'(v) ^ 8'h5A);
            sp_exp = (v == 0) ? 8'h00 : 8'(v - 1);
            check(sp_value == sp_exp, (v == 0) ? "R4 pop floor" : "R3 pop decrement",
                  sp_value, sp_exp);
        end

        // R4: push after floor
        load_sp(8'h00);
        run_cmd(4'd2, 1, "R4");
        check(sp_value == 8'h00, "R4 floor hold", sp_value, 0);
        data_in = 8'h33;
        run_cmd(4'd1, 1, "R4");
        check(sp_value == 8'h01, "R4 push after floor sp", sp_value, 1);
        check(mem[1] == 8'h33, "R4 push after floor addr1", mem[1], 8'h33);
        after_done();

        // R2 push sweep then R3 LIFO pops
        load_sp(8'd10);
        for (int i = 0; i < 40; i++) begin
            data_in = 8'(i * 7 + 3);
            run_cmd(4'd1, 1, "R2");
            check(sp_value == 8'(11 + i), "R2 push sp", sp_value, 11 + i);
            check(mem[11 + i] == 8'(i * 7 + 3), "R2 push data", mem[11 + i], i * 7 + 3);
        end
        for (int i = 39; i >= 0; i--) begin
            run_cmd(4'd2, 1, "R3");
            check(pop_byte == 8'(i * 7 + 3), "R3 LIFO data", pop_byte, i * 7 + 3);
            check(sp_value == 8'(10 + i), "R3 LIFO sp", sp_value, 10 + i);
        end

        // R8 status push/pop
        load_sp(8'h30);
        status_in = 8'hA5; data_in = 8'h11;
        run_cmd(4'd3, 1, "R8");
        check(mem[8'h31] == 8'hA5, "R8 status pushed", mem[8'h31], 8'hA5);
        status_in = 8'h00;
        run_cmd(4'd4, 1, "R8");
        check(ret_status == 8'hA5, "R8 status popped", ret_status, 8'hA5);
        check(sp_value == 8'h30, "R8 sp restored", sp_value, 8'h30);

        // R5 / R6 call or trap then return, several addresses
        for (int j = 0; j < 8; j++) begin
            base = 8'(8'h20 + j * 9);
            pcv  = 16'(16'h1234 * (j + 1) + j);
            load_sp(base);
            pc_in = pcv;
            run_cmd((j % 2) ? 4'd6 : 4'd5, 2, "R5");
            check(mem[7'(base + 1)] == pcv[15:8], "R5 high byte first", mem[7'(base + 1)], pcv[15:8]);
            check(mem[7'(base + 2)] == pcv[7:0], "R5 low byte second", mem[7'(base + 2)], pcv[7:0]);
            check(sp_value == 8'(base + 2), "R5 sp plus two", sp_value, base + 2);
            pc_in = 16'h0;
            run_cmd(4'd7, 2, "R6");
            check(ret_pc == pcv, "R6 return address", ret_pc, pcv);
            check(sp_value == base, "R6 sp restored", sp_value, base);
            after_done();
        end

        // R7 interrupt frame: status, then call-style address; pop it back
        for (int j = 0; j < 4; j++) begin
            base = 8'(8'h50 + j * 5);
            pcv  = 16'(16'hC0DE ^ (j * 16'h0F31));
            load_sp(base);
            status_in = 8'(8'h81 + j);
            run_cmd(4'd3, 1, "R7");
            pc_in = pcv;
            run_cmd(4'd6, 2, "R7");
            status_in = 8'h00; pc_in = 16'h0;
            run_cmd(4'd8, 3, "R7");
            check(ret_pc == pcv, "R7 return address", ret_pc, pcv);
            check(ret_status == 8'(8'h81 + j), "R7 return status", ret_status, 8'h81 + j);
            check(sp_value == base, "R7 sp minus three", sp_value, base);
        end

        // R10 command during busy ignored
        load_sp(8'h40);
        poke(7'h43, 8'hEE);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 4'd5; pc_in = 16'h5566;
        @(negedge clk);
        cmd_code = 4'd1; data_in = 8'h77;
        check(busy == 1'b1, "R10 busy during frame", busy, 1);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_code = 4'd0;
        @(negedge clk);
        check(done == 1'b1, "R10 frame completes", done, 1);
        @(negedge clk);
        @(negedge clk);
        check(sp_value == 8'h42, "R10 sp untouched by ignored push", sp_value, 8'h42);
        check(mem[7'h43] == 8'hEE, "R10 memory untouched", mem[7'h43], 8'hEE);
        check(!busy, "R10 idle again", busy, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule